// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block models the management register file of a single Ethernet PHY. A host reaches it through a one-cycle request port that carries a 10-bit register address and 16-bit write data. The block keeps a small set of live registers: control, status, advertisement, interrupt source and interrupt mask. It answers identifier, partner-ability, expansion and special-status reads with constants. Every read returns its data one cycle after the request, together with a valid strobe.

A `link_up` input stands in for the line side. A change of that input updates the link and negotiation bits in the status register and latches interrupt sources. A level interrupt output stays high while any source is pending and also enabled in the mask. Negotiation is not carried out. When it is enabled, the status register reports it as finished at once.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After `rst`, control holds 0x3000, advertisement 0x01E1, mask 0 and source 0. Status starts at 0x7809. On the first cycle after reset the link state is applied once, as described in R10.
- R2: Only address bits [4:0] select a register. The upper bits (the PHY slot) are ignored for both reads and writes.
- R3: A write to index 0 with bit 15 set restores the R1 state, and the link is applied again one cycle later. Any other write to index 0 stores the data ANDed with 0x7980.
- R4: A write to index 0 with bit 12 set, and without bit 15, sets status bit 5 in the same cycle.
- R5: A write to index 4 keeps bits 11, 10, 8, 7, 6, 5 and 4:0 of the data. Bit 7 is then forced to 1.
- R6: Index 2 reads 0x0007 and index 3 reads 0xC0D1. Index 5 reads 0x0DE1, index 6 reads 0x0001 and index 17 reads 0x0040.
- R7: A read of index 29 returns the 8-bit source register in bits [7:0] and then clears it. A source set by a link event in that same cycle survives the clear.
- R8: A write to index 30 stores data bits [7:0] as the mask. Index 30 reads back the mask in bits [7:0].
- R9: `irq` is high exactly while (source AND mask) is nonzero.
- R10: On a link change to down, status bits 2 and 5 clear and source bit 4 sets. On a change to up, status bits 2 and 5 set and source bits 6 and 7 set. A steady link sets nothing.
- R11: Any index not named above reads 0 and ignores writes. Every read raises `rsp_valid` for exactly one cycle, on the cycle after the request. At all other times `rsp_valid` and `rsp_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Slot in [9:5], register index in [4:0] |
| req_wdata | input | 16 | Write data |
| link_up | input | 1 | Current line link state |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Read data |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `link_up` is synchronous to `clk`. They also assume that a request lasts a single cycle and that reads and writes are never asked for together. The stimulus drives every input on the falling edge, keeps `req_valid` one cycle wide, and issues at most one access per cycle. It toggles `link_up` both during idle cycles and in the same cycle as clears and writes. This exercises the priority of a link event over a clear-on-read and over an autonegotiation-enable write.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 5;
    localparam int SRC_W  = 8;

    localparam logic [IDX_W-1:0] IDX_CTRL  = 5'd0;
    localparam logic [IDX_W-1:0] IDX_STAT  = 5'd1;
    localparam logic [IDX_W-1:0] IDX_ID_HI = 5'd2;
    localparam logic [IDX_W-1:0] IDX_ID_LO = 5'd3;
    localparam logic [IDX_W-1:0] IDX_ADV   = 5'd4;
    localparam logic [IDX_W-1:0] IDX_LPA   = 5'd5;
    localparam logic [IDX_W-1:0] IDX_EXP   = 5'd6;
    localparam logic [IDX_W-1:0] IDX_SPEC  = 5'd17;
    localparam logic [IDX_W-1:0] IDX_ISRC  = 5'd29;
    localparam logic [IDX_W-1:0] IDX_IMSK  = 5'd30;

    localparam logic [DATA_W-1:0] CTRL_INIT  = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_INIT  = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_INIT   = 16'h01E1;
    localparam logic [DATA_W-1:0] CTRL_KEEP  = 16'h7980;
    localparam logic [DATA_W-1:0] ADV_KEEP   = 16'h0DFF;
    localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;
    localparam logic [DATA_W-1:0] ID_HI_VAL  = 16'h0007;
    localparam logic [DATA_W-1:0] ID_LO_VAL  = 16'hC0D1;
    localparam logic [DATA_W-1:0] LPA_VAL    = 16'h0DE1;
    localparam logic [DATA_W-1:0] EXP_VAL    = 16'h0001;
    localparam logic [DATA_W-1:0] SPEC_VAL   = 16'h0040;

    localparam int SOFT_RST_BIT = 15;
    localparam int AN_EN_BIT    = 12;
    localparam logic [DATA_W-1:0] STAT_LINK   = 16'h0004;
    localparam logic [DATA_W-1:0] STAT_ANDONE = 16'h0020;

    localparam logic [SRC_W-1:0] SRC_LDOWN  = 8'h10;
    localparam logic [SRC_W-1:0] SRC_ANDONE = 8'h40;
    localparam logic [SRC_W-1:0] SRC_ENERGY = 8'h80;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } mreq_t;

    typedef struct packed {
        logic valid;
        logic up;
    } link_evt_t;

    function automatic logic [DATA_W-1:0] adv_filter(input logic [DATA_W-1:0] d);
        return (d & ADV_KEEP) | ADV_FORCE;
    endfunction

    function automatic logic [DATA_W-1:0] link_status(input logic [DATA_W-1:0] s,
                                                      input link_evt_t e);
        logic [DATA_W-1:0] r;
        r = s;
        if (e.valid) begin
            if (e.up) r = s | STAT_LINK | STAT_ANDONE;
            else      r = s & ~(STAT_LINK | STAT_ANDONE);
        end
        return r;
    endfunction

endpackage

// File: rtl/phy_link_watch.sv
module phy_link_watch
    import phy_mgmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      soft_rst,
    input  logic      link_up,
    output link_evt_t evt
);
    logic prev_q;
    logic reeval_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            reeval_q <= 1'b1;
        end else begin
            prev_q   <= link_up;
            reeval_q <= soft_rst;
        end
    end

    always_comb begin
        evt.valid = !soft_rst && (reeval_q || (link_up != prev_q));
        evt.up    = link_up;
    end

    // R10: a link that holds its value raises no event
    a_r10_steady_quiet: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && $stable(link_up) && !reeval_q) |=> (!evt.valid || $changed(link_up) || $past(soft_rst)));

endmodule

// File: rtl/phy_base_regs.sv
module phy_base_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  mreq_t             req,
    input  link_evt_t         evt,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] adv_q
);
    logic [DATA_W-1:0] ctrl_n, stat_n, adv_n;

    always_comb begin
        ctrl_n = ctrl_q;
        stat_n = stat_q;
        adv_n  = adv_q;
        if (req.wr && req.idx == IDX_CTRL) begin
            ctrl_n = req.data & CTRL_KEEP;
            if (req.data[AN_EN_BIT]) stat_n = stat_n | STAT_ANDONE;
        end
        if (req.wr && req.idx == IDX_ADV) adv_n = adv_filter(req.data);
        stat_n = link_status(stat_n, evt);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctrl_q <= CTRL_INIT;
            stat_q <= STAT_INIT;
            adv_q  <= ADV_INIT;
        end else begin
            ctrl_q <= ctrl_n;
            stat_q <= stat_n;
            adv_q  <= adv_n;
        end
    end

    // R3: a soft reset brings control back to its default
    a_r3_soft_default: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ctrl_q == CTRL_INIT && adv_q == ADV_INIT));

    // R4: enabling negotiation reports it complete at once
    a_r4_an_done: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.idx == IDX_CTRL && req.data[AN_EN_BIT] && !soft_rst && !evt.valid)
        |=> stat_q[5]);

    // R10: link down clears link and negotiation-complete
    a_r10_down_clears: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !evt.up) |=> (!stat_q[2] && !stat_q[5]));

endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  mreq_t            req,
    input  link_evt_t        evt,
    output logic [SRC_W-1:0] src_q,
    output logic [SRC_W-1:0] mask_q,
    output logic             irq
);
    logic [SRC_W-1:0] src_n, mask_n;

    always_comb begin
        src_n  = src_q;
        mask_n = mask_q;
        if (req.rd && req.idx == IDX_ISRC) src_n = '0;
        if (evt.valid) begin
            if (evt.up) src_n = src_n | SRC_ANDONE | SRC_ENERGY;
            else        src_n = src_n | SRC_LDOWN;
        end
        if (req.wr && req.idx == IDX_IMSK) mask_n = req.data[SRC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            src_q  <= '0;
            mask_q <= '0;
        end else begin
            src_q  <= src_n;
            mask_q <= mask_n;
        end
    end

    assign irq = |(src_q & mask_q);

    // R7: a clear with no competing event empties the source register
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.idx == IDX_ISRC && !evt.valid) |=> (src_q == '0));

    // R9: a zero mask silences the interrupt
    a_r9_mask_zero: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.idx == IDX_IMSK && req.data[SRC_W-1:0] == '0) |=> !irq);

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          link_up,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          irq
);
    mreq_t             req;
    link_evt_t         evt;
    logic              soft_rst;
    logic [DATA_W-1:0] ctrl_q, stat_q, adv_q;
    logic [SRC_W-1:0]  src_q, mask_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        req.wr   = req_valid && req_write;
        req.rd   = req_valid && !req_write;
        req.idx  = req_addr[IDX_W-1:0];
        req.data = req_wdata[DATA_W-1:0];
    end

    assign soft_rst = req.wr && req.idx == IDX_CTRL && req.data[SOFT_RST_BIT];

    phy_link_watch u_link (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .link_up(link_up), .evt(evt)
    );

    phy_base_regs u_base (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .req(req), .evt(evt),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .adv_q(adv_q)
    );

    phy_irq_regs u_irq (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .req(req), .evt(evt),
        .src_q(src_q), .mask_q(mask_q), .irq(irq)
    );

    always_comb begin
        case (req.idx)
            IDX_CTRL:  rd_mux = ctrl_q;
            IDX_STAT:  rd_mux = stat_q;
            IDX_ID_HI: rd_mux = ID_HI_VAL;
            IDX_ID_LO: rd_mux = ID_LO_VAL;
            IDX_ADV:   rd_mux = adv_q;
            IDX_LPA:   rd_mux = LPA_VAL;
            IDX_EXP:   rd_mux = EXP_VAL;
            IDX_SPEC:  rd_mux = SPEC_VAL;
            IDX_ISRC:  rd_mux = {{(DATA_W-SRC_W){1'b0}}, src_q};
            IDX_IMSK:  rd_mux = {{(DATA_W-SRC_W){1'b0}}, mask_q};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req.rd;
            rsp_rdata <= req.rd ? DW'(rd_mux) : '0;
        end
    end

    // R11: every read answers on the next cycle, nothing else does
    a_r11_rsp_timing: assert property (@(posedge clk) disable iff (rst)
        req.rd |=> rsp_valid);
    a_r11_rsp_quiet: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> (!rsp_valid && rsp_rdata == '0));

endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic        link_up   = 1'b1;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        irq;

    always #5 clk = ~clk;

    phy_mgmt_regs uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .link_up(link_up),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    int    n_run = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference state
    int m_ctrl, m_stat, m_adv, m_mask, m_src;
    int m_prev, m_reeval, m_rv, m_rd;

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int ref_read(int idx);
        case (idx)
            0: return m_ctrl;
            1: return m_stat;
            2: return 'h0007;
            3: return 'hC0D1;
            4: return m_adv;
            5: return 'h0DE1;
            6: return 'h0001;
            17: return 'h0040;
            29: return m_src;
            30: return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic ref_defaults();
        m_ctrl = 'h3000; m_stat = 'h7809; m_adv = 'h01E1;
        m_mask = 0; m_src = 0; m_reeval = 1;
    endtask

    always @(posedge clk) begin
        int idx, w;
        idx = int'(req_addr) % 32;
        w   = int'(req_wdata);
        if (rst) begin
            ref_defaults();
            m_prev = 0; m_rv = 0; m_rd = 0;
        end else begin
            m_rv = (req_valid && !req_write) ? 1 : 0;
            m_rd = m_rv ? ref_read(idx) : 0;
            if (req_valid && req_write && idx == 0 && w >= 'h8000) begin
                ref_defaults();
            end else begin
                if (req_valid && req_write) begin
                    if (idx == 0) begin
                        m_ctrl = w & 'h7980;
                        if ((w & 'h1000) != 0) m_stat = m_stat | 'h20;
                    end
                    if (idx == 4) m_adv = (w & 'h0DFF) | 'h80;
                    if (idx == 30) m_mask = w % 256;
                end
                if (m_rv == 1 && idx == 29) m_src = 0;
                if (m_reeval == 1 || int'(link_up) != m_prev) begin
                    if (link_up) begin
                        m_stat = m_stat | 'h24;
                        m_src  = m_src | 'hC0;
                    end else begin
                        m_stat = m_stat & ~'h24;
                        m_src  = m_src | 'h10;
                    end
                end
                m_reeval = 0;
            end
            m_prev = int'(link_up);
        end
        #1;
        check({cur_req, " rsp_valid"}, int'(rsp_valid), m_rv);
        check({cur_req, " rsp_rdata"}, int'(rsp_rdata), m_rd);
        check({cur_req, " irq"}, int'(irq), ((m_src & m_mask) != 0) ? 1 : 0);
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 10'(addr); req_wdata = 16'(data);
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(string tag, int addr, int exp);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 10'(addr);
        @(negedge clk);
        req_valid = 0;
        check({tag, " read"}, int'(rsp_rdata), exp);
    endtask

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        // R1 defaults with the link applied once
        cur_req = "R1";
        check("R1 irq", int'(irq), 0);
        rd("R1 status", 1, 'h782D);
        rd("R1 control", 0, 'h3000);
        rd("R1 advert", 4, 'h01E1);
        rd("R1 mask", 30, 0);
        // R6 constants
        cur_req = "R6";
        rd("R6 id hi", 2, 'h0007);
        rd("R6 id lo", 3, 'hC0D1);
        rd("R6 partner", 5, 'h0DE1);
        rd("R6 expansion", 6, 'h0001);
        rd("R6 special", 17, 'h0040);
        // R8 / R9 mask
        cur_req = "R8";
        wr(30, 'hFFC0);
        rd("R8 mask", 30, 'h00C0);
        cur_req = "R9";
        check("R9 irq on", int'(irq), 1);
        // R7 clear on read
        cur_req = "R7";
        rd("R7 src", 29, 'h00C0);
        check("R7 irq off", int'(irq), 0);
        rd("R7 src empty", 29, 0);
        // R10 link transitions
        cur_req = "R10";
        link_up = 0;
        idle(2);
        check("R10 irq masked", int'(irq), 0);
        rd("R10 status down", 1, 'h7809);
        wr(30, 'h10);
        check("R9 irq down", int'(irq), 1);
        rd("R10 src down", 29, 'h10);
        rd("R10 steady", 29, 0);
        link_up = 1;
        idle(2);
        rd("R10 status up", 1, 'h782D);
        rd("R10 src up", 29, 'hC0);
        // R2 slot bits ignored
        cur_req = "R2";
        wr(32 * 5 + 4, 'hFFFF);
        rd("R2 adv", 4, 'h0DFF);
        rd("R2 alias", 36, 'h0DFF);
        rd("R2 high unlisted", 1000, 0);
        // R5 advertisement
        cur_req = "R5";
        wr(4, 'h0000);
        rd("R5 forced bit", 4, 'h0080);
        wr(4, 'hF200);
        rd("R5 dropped bits", 4, 'h0080);
        // R3 control mask
        cur_req = "R3";
        wr(0, 'h7FFF);
        rd("R3 masked", 0, 'h7980);
        wr(0, 'h0000);
        rd("R3 cleared", 0, 0);
        // R4 instant negotiation
        cur_req = "R4";
        link_up = 0;
        idle(2);
        rd("R4 before", 1, 'h7809);
        wr(0, 'h1000);
        rd("R4 after", 1, 'h7829);
        // R3 soft reset
        cur_req = "R3";
        wr(30, 'hFF);
        wr(0, 'h8000);
        idle(1);
        rd("R3 ctrl", 0, 'h3000);
        rd("R3 adv", 4, 'h01E1);
        rd("R3 mask", 30, 0);
        rd("R3 status", 1, 'h7809);
        rd("R3 src", 29, 'h10);
        // R11 unlisted registers
        cur_req = "R11";
        wr(18, 'hFFFF);
        rd("R11 reg18", 18, 0);
        wr(31, 'hFFFF);
        rd("R11 reg31", 31, 0);
        rd("R11 reg27", 27, 0);
        rd("R11 status kept", 1, 'h7809);
        // mixed traffic with link toggles, compared every cycle
        cur_req = "R9";
        for (int i = 0; i < 1500; i++) begin
            int pick;
            int idxs [8] = '{0, 1, 4, 29, 30, 17, 5, 12};
            @(negedge clk);
            pick = int'($urandom % 8);
            if ($urandom % 7 == 0) link_up = ~link_up;
            req_valid = ($urandom % 3 != 0);
            req_write = ($urandom % 2 == 0);
            req_addr  = 10'((($urandom % 32) * 32) + idxs[pick]);
            req_wdata = 16'($urandom);
            if (req_write && idxs[pick] == 0 && ($urandom % 4 != 0))
                req_wdata[15] = 1'b0;
        end
        @(negedge clk);
        req_valid = 0;
        idle(2);
        finish_run();
    end

endmodule